// File: doc/BRIEF.md
# Six-Leg Elliptical Gait Setpoint Generator

This block turns one speed word into position demands for a six-legged walker. A single 16-bit phase accumulator is shared by all legs. On every update strobe the accumulator advances by the speed word. Each leg then reads the accumulator through a fixed phase offset. Two demands are produced per leg: an x demand and a y demand taken a quarter turn later. The leg tip therefore traces an ellipse, and the two axis amplitudes set its shape.

Two gait patterns are available. The wave gait spreads the legs of one side a third of a turn apart and mirrors the opposite side half a turn away. The tripod gait puts front and rear legs together, with the middle leg opposite them. A request to change gait is applied only on the update where the accumulator rolls over, so the pattern never changes in the middle of a stride. The sine is built from a 256-step quarter wave, computed rather than stored, and scaled by an 8-bit amplitude with rounding. Downstream position loops latch the setpoints when the update pulse is high.

Top module: `gait_phase_gen`

## Requirements
- R1: While reset is low, all setpoints are zero, `upd` is low, the accumulator is zero and the wave gait is selected.
- R2: On each `step` the accumulator becomes (accumulator + `speed`) mod 65536, and that step's setpoints use the advanced value.
- R3: Setpoints and `upd` change on the clock edge that samples `step` high; `upd` is high for that one cycle only; without `step` all setpoints hold.
- R4: For a 16-bit phase p, with quadrant q = p[15:14], index i = p[13:6] and t(k) = floor(32767·k·(512−k)/65536), the sine is +t(i) for q=0, +t(255−i) for q=1, −t(i) for q=2 and −t(255−i) for q=3.
- R5: Each setpoint is floor((sine · amp + 128) / 256), with amp an unsigned 8-bit value; an amplitude of zero gives zero.
- R6: Leg n (0..5) occupies bits [16n+15:16n] of `set_x` and `set_y`; legs 0, 1, 2 are the front, middle and rear legs of the first side, and legs 3, 4, 5 are the same legs of the second side.
- R7: In the wave gait the first-side offsets are 0, 21845 and 43690 counts for front, middle and rear, and each second-side leg adds 32768 to its first-side partner (mod 65536).
- R8: In the tripod gait the first-side offsets are 0, 32768 and 0, and each second-side leg adds 32768 to its partner.
- R9: The y phase of every leg is its x phase plus 16384 (mod 65536).
- R10: `tripod` is taken only on a `step` whose addition carries out of 16 bits, and the gait it selects (1 = tripod, 0 = wave) already applies to that step's setpoints; on any other step it is ignored.
- R11: `amp_x` scales every x setpoint and `amp_y` every y setpoint, both sampled with each `step`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step | input | 1 | Update strobe: advance the phase and refresh the setpoints |
| speed | input | 16 | Phase increment per update |
| amp_x | input | 8 | Unsigned amplitude for the x axis |
| amp_y | input | 8 | Unsigned amplitude for the y axis |
| tripod | input | 1 | Requested gait, 1 = tripod, 0 = wave |
| upd | output | 1 | High for one cycle when new setpoints are present |
| set_x | output | 96 | Six signed 16-bit x setpoints |
| set_y | output | 96 | Six signed 16-bit y setpoints |

## Verification
The accumulator rollover and a gait request change can land in the same update, and the new offsets then have to reach that very update's setpoints. The bench computes the speed that brings the accumulator exactly to zero and flips `tripod` on that step, so the carry is as narrow as it can be. It also raises the request on steps that do not wrap and checks at the outputs that the old gait stays in force. Every lane of both axes is compared with a model of the offset table, the quarter-wave sine and the rounding rule.

// File: rtl/gait_phase_gen.sv
module gait_phase_gen #(
  parameter int PW = 16,
  parameter int AW = 8,
  parameter int OW = 16,
  parameter int TB = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic [PW-1:0]      speed,
  input  logic [AW-1:0]      amp_x,
  input  logic [AW-1:0]      amp_y,
  input  logic               tripod,
  output logic               upd,
  output logic [6*OW-1:0]    set_x,
  output logic [6*OW-1:0]    set_y
);
  localparam int LEGS = 6;
  localparam int PRW = OW + AW + 1;
  localparam logic [PW-1:0] HALF  = {1'b1, {(PW-1){1'b0}}};
  localparam logic [PW-1:0] QTR   = {2'b01, {(PW-2){1'b0}}};
  localparam logic [PW-1:0] THIRD = PW'(((longint'(1) << PW) + 1) / 3);
  localparam logic [PW-1:0] TWO3  = PW'(2 * (((longint'(1) << PW) + 1) / 3));
  localparam longint PEAK = (longint'(1) << (OW-1)) - 1;
  localparam logic signed [PRW-1:0] RND = PRW'(longint'(1) << (AW-1));

  logic [PW-1:0] acc_q;
  logic          trip_q;
  logic [PW:0]   sum;
  logic [PW-1:0] acc_n;
  logic          trip_n;
  logic [LEGS*OW-1:0] nx_x, nx_y;

  assign sum    = {1'b0, acc_q} + {1'b0, speed};
  assign acc_n  = sum[PW-1:0];
  assign trip_n = sum[PW] ? tripod : trip_q;

  function automatic logic [PW-1:0] leg_off(input int leg, input logic trip);
    logic [PW-1:0] base;
    int pos;
    pos = leg % 3;
    if (trip) base = (pos == 1) ? HALF : '0;
    else      base = (pos == 0) ? '0 : ((pos == 1) ? THIRD : TWO3);
    return (leg >= 3) ? base + HALF : base;
  endfunction

  function automatic logic signed [OW-1:0] sine(input logic [PW-1:0] p);
    logic [TB-1:0] k;
    longint m;
    logic [OW-1:0] mag;
    k = p[PW-3 -: TB];
    if (p[PW-2]) k = ~k;
    m = PEAK * longint'(k) * ((longint'(1) << (TB+1)) - longint'(k));
    mag = OW'(m >> (2*TB));
    return p[PW-1] ? -$signed(mag) : $signed(mag);
  endfunction

  function automatic logic [OW-1:0] scale(input logic signed [OW-1:0] s, input logic [AW-1:0] a);
    logic signed [PRW-1:0] prod;
    prod = PRW'(s) * $signed({1'b0, a}) + RND;
    prod = prod >>> AW;
    return prod[OW-1:0];
  endfunction

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    logic [PW-1:0] ph_x, ph_y;
    assign ph_x = acc_n + leg_off(g, trip_n);
    assign ph_y = ph_x + QTR;
    assign nx_x[g*OW +: OW] = scale(sine(ph_x), amp_x);
    assign nx_y[g*OW +: OW] = scale(sine(ph_y), amp_y);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      trip_q <= 1'b0;
      upd    <= 1'b0;
      set_x  <= '0;
      set_y  <= '0;
    end else begin
      upd <= step;
      if (step) begin
        acc_q  <= acc_n;
        trip_q <= trip_n;
        set_x  <= nx_x;
        set_y  <= nx_y;
      end
    end
  end
endmodule

module gait_phase_gen_chk #(
  parameter int PW = 16,
  parameter int AW = 8,
  parameter int OW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step,
  input logic [PW-1:0]   speed,
  input logic [AW-1:0]   amp_x,
  input logic            upd,
  input logic [6*OW-1:0] set_x,
  input logic [6*OW-1:0] set_y,
  input logic [PW-1:0]   acc_q,
  input logic            trip_q
);
  logic [PW:0] chk_sum;
  assign chk_sum = {1'b0, acc_q} + {1'b0, speed};

  p_upd_rise_r3: assert property (@(posedge clk) disable iff (!rst_n) step |=> upd);
  p_upd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n) !step |=> !upd);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(set_x) && $stable(set_y)));
  p_acc_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> acc_q == PW'($past(acc_q) + $past(speed)));
  p_gait_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && chk_sum[PW]) |=> $stable(trip_q));
  p_zero_amp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && amp_x == '0) |=> set_x == '0);
  p_tripod_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && trip_q) |-> (set_x[0 +: OW] == set_x[2*OW +: OW] && set_y[0 +: OW] == set_y[2*OW +: OW]));
endmodule

bind gait_phase_gen gait_phase_gen_chk #(.PW(PW), .AW(AW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .speed(speed), .amp_x(amp_x),
  .upd(upd), .set_x(set_x), .set_y(set_y), .acc_q(acc_q), .trip_q(trip_q)
);

// File: tb/gait_phase_gen_bench.sv
`timescale 1ns/1ps
module gait_phase_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [15:0] speed = '0;
  logic [7:0]  amp_x = '0, amp_y = '0;
  logic        tripod = 1'b0;
  logic        upd;
  logic [95:0] set_x, set_y;

  gait_phase_gen u_gait_phase_gen (
    .clk(clk), .rst_n(rst_n), .step(step), .speed(speed), .amp_x(amp_x),
    .amp_y(amp_y), .tripod(tripod), .upd(upd), .set_x(set_x), .set_y(set_y));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [191:0] exp_q[$];
  string tag_q[$];
  logic [15:0] m_acc = '0;
  logic        m_trip = 1'b0;
  logic [95:0] last_x = '0, last_y = '0;

  function automatic int bt(input int k);
    longint m;
    m = 64'd32767 * longint'(k) * longint'(512 - k);
    return int'(m / 65536);
  endfunction

  function automatic int bsin(input logic [15:0] p);
    int i;
    i = int'(p[13:6]);
    case (p[15:14])
      2'd0: return bt(i);
      2'd1: return bt(255 - i);
      2'd2: return -bt(i);
      default: return -bt(255 - i);
    endcase
  endfunction

  function automatic logic [15:0] bscale(input int s, input int a);
    int r;
    r = (s * a + 128) >>> 8;
    return r[15:0];
  endfunction

  function automatic logic [15:0] boff(input int leg, input logic trip);
    logic [15:0] b;
    int pos;
    pos = leg % 3;
    if (trip) b = (pos == 1) ? 16'd32768 : 16'd0;
    else b = (pos == 0) ? 16'd0 : ((pos == 1) ? 16'd21845 : 16'd43690);
    return (leg >= 3) ? b + 16'd32768 : b;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input logic [95:0] act, input logic [95:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic do_step(input logic [15:0] spd, input logic [7:0] ax, input logic [7:0] ay,
                         input logic trq, input string tag);
    logic [16:0] s;
    logic [191:0] e;
    s = {1'b0, m_acc} + {1'b0, spd};
    m_acc = s[15:0];
    if (s[16]) m_trip = trq;
    for (int g = 0; g < 6; g++) begin
      logic [15:0] px, py;
      px = m_acc + boff(g, m_trip);
      py = px + 16'd16384;
      e[g*16 +: 16] = bscale(bsin(px), int'(ax));
      e[96 + g*16 +: 16] = bscale(bsin(py), int'(ay));
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    step = 1'b1; speed = spd; amp_x = ax; amp_y = ay; tripod = trq;
    @(posedge clk); #1;
    step = 1'b0; tripod = ~trq;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (upd) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected upd", 96'(upd), 96'd0);
        end else begin
          logic [191:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          for (int g = 0; g < 6; g++) begin
            check(set_x[g*16 +: 16] == e[g*16 +: 16], t, $sformatf("x leg %0d", g),
                  96'(set_x[g*16 +: 16]), 96'(e[g*16 +: 16]));
            check(set_y[g*16 +: 16] == e[96 + g*16 +: 16], t, $sformatf("y leg %0d", g),
                  96'(set_y[g*16 +: 16]), 96'(e[96 + g*16 +: 16]));
          end
        end
        last_x = set_x;
        last_y = set_y;
      end else begin
        check(set_x == last_x && set_y == last_y, "R3", "hold without step", set_x ^ set_y, last_x ^ last_y);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(5);
    @(negedge clk);
    check(set_x == '0 && set_y == '0, "R1", "outputs in reset", set_x | set_y, 96'd0);
    check(upd == 1'b0, "R1", "upd in reset", 96'(upd), 96'd0);
    rst_n = 1'b1;
    idle(2);
    // R1 R2 R4 R6 R7 R9: wave gait from zero phase at full scale
    do_step(16'h1000, 8'd255, 8'd255, 1'b0, "R7");
    do_step(16'h2345, 8'd255, 8'd128, 1'b0, "R9");
    // R5 R11: independent amplitudes and zero amplitude
    do_step(16'h0800, 8'd0, 8'd200, 1'b0, "R5");
    do_step(16'h0800, 8'd77, 8'd0, 1'b0, "R11");
    idle(4);
    // R10: gait request on non-wrapping steps is ignored
    do_step(16'h0100, 8'd255, 8'd255, 1'b1, "R10");
    do_step(16'h0040, 8'd180, 8'd90, 1'b1, "R10");
    // R10 R8: exact rollover together with a gait request
    do_step(16'(17'h10000 - {1'b0, m_acc}), 8'd255, 8'd255, 1'b1, "R10");
    do_step(16'h1357, 8'd255, 8'd255, 1'b0, "R8");
    do_step(16'h5555, 8'd100, 8'd250, 1'b0, "R8");
    idle(3);
    // R10: rollover back to wave gait
    do_step(16'hF000, 8'd255, 8'd64, 1'b0, "R10");
    do_step(16'h0777, 8'd255, 8'd64, 1'b0, "R6");
    // R4 R2: sweep through every quadrant with wrapping
    for (int i = 0; i < 40; i++)
      do_step(16'h0D31, 8'(200 + i), 8'(i * 6), i[0], "R4");
    idle(4);
    check(exp_q.size() == 0, "R3", "all updates seen", 96'(exp_q.size()), 96'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule